// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This block is a hardware breakpoint unit with four channels for a simple in-order CPU. Each channel holds a target address, an address mask and a control word. The unit compares every instruction-start fetch on the fetch bus against all channels. It puts the per-channel hit vector in a small in-order queue, so the tag follows the fetched instruction until it reaches the execute stage. Flushes drop every queued entry that has not executed. A fetch match alone never causes a break. Only an instruction that really executes can raise one.

At execution, each channel's break is taken either before or after the matching instruction, as its control word selects. The CPU reports three things with each executed instruction: whether it is a delayed branch, whether it blocks interrupts for the next instruction, and whether the pipeline is flushed. When the break point cannot accept an interrupt, the request is held. This happens in a delay slot, after an instruction that blocks interrupts, or after a delayed branch. The held request is delivered at the first boundary that does accept an interrupt. The unit drives one registered request line, which stays high until the CPU acknowledges it, and a sticky flag for each channel.

Software programs the channels through a write-only port. The address is `{channel, select}`. Select 0 is the target address, 1 is the mask, 2 is the control word and 3 is the status of that channel.

Top module: `ifbrk_unit`

## Requirements
- R1: After synchronous reset, `brk_irq` is 0, every `brk_flag` bit is 0, and every channel is disabled, so an executed instruction at any address raises nothing.
- R2: A channel takes part only when bits [4:0] of its control word equal 5'b01111. Bit 0 is CPU master, bit 1 is instruction fetch, bit 2 is read, and bits [4:3]=01 is word size. Any other value never matches.
- R3: A channel hits when ((fetch address XOR target) AND NOT mask) is zero, with address bit 0 always excluded. Only fetches with `fet_start`=1 are considered. A halfword that continues an instruction (`fet_start`=0) never matches, even at the target address.
- R4: Bit 8 of the control word selects the break point: 0 breaks before the instruction executes, 1 breaks after it.
- R5: A before-execution break is raised only when the tagged instruction executes (`ex_valid` with that instruction at the queue head). `brk_irq` and the flags change on the clock edge that samples `ex_valid`. A fetch match with no execution raises nothing.
- R6: Instructions that are queued but discarded by `ex_flush` never cause a break in either mode.
- R7: An after-execution break is delivered on the execute event of its instruction when that instruction is neither a delayed branch nor interrupt-blocking.
- R8: A before-execution break is held when its instruction follows a delayed branch or an interrupt-blocking instruction. It is delivered at the next boundary that accepts interrupts.
- R9: An after-execution break on a delayed branch or on an interrupt-blocking instruction is held. It is delivered at the next boundary that accepts interrupts.
- R10: `brk_irq` stays high until `brk_ack` is sampled high, and then drops on that edge.
- R11: Flags are sticky. Writing select 3 of a channel with data bit 0 = 0 clears that channel's flag. Data bit 0 = 1 leaves it unchanged. Acknowledging the request does not clear any flag.
- R12: When several channels hit the same instruction, a single request is raised and the flag of every hitting channel is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CHW+2 | {channel, select}; select 0 target, 1 mask, 2 control, 3 status |
| cfg_wdata | input | AW | Write data |
| fet_valid | input | 1 | Instruction fetch on the bus this cycle |
| fet_start | input | 1 | Fetched halfword is the start of an instruction |
| fet_addr | input | AW | Fetch address |
| ex_valid | input | 1 | Oldest fetched instruction executes this cycle |
| ex_branch | input | 1 | The executing instruction is a delayed branch |
| ex_inhibit | input | 1 | The executing instruction blocks interrupts for the next one |
| ex_flush | input | 1 | Discard all fetched, not yet executed instructions |
| brk_ack | input | 1 | CPU acknowledges the break request |
| brk_irq | output | 1 | Registered break interrupt request |
| brk_flag | output | NCH | Sticky per-channel break flags |

## Verification
The checker assumes two things about the CPU side. `ex_valid` never arrives while no fetched instruction is queued, and no more than QDEPTH instruction starts are outstanding. Without these, the queue head would not belong to the executing instruction. `ex_branch`, `ex_inhibit` and `ex_flush` are taken as meaningful only while `ex_valid` is high. The stimulus issues each instruction's fetch before its execute event and keeps at most two starts outstanding. It raises the branch, inhibit and flush indications only together with `ex_valid`.

// File: rtl/ifbrk_pkg.sv
package ifbrk_pkg;
  // Register select field, low two bits of the write address
  typedef enum logic [1:0] {
    SEL_TARGET = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } sel_e;

  // Bus-cycle setting that enables instruction-fetch matching:
  // bit0 cpu, bit1 ifetch, bit2 read, bits[4:3] = 01 word size
  localparam logic [4:0] CYC_IFETCH_WORD = 5'b01111;
  localparam int         CTRL_POST_BIT   = 8;
endpackage

// File: rtl/ifbrk_chan.sv
module ifbrk_chan
  import ifbrk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  sel_e          wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] fet_addr,
  output logic          hit,
  output logic          post_mode
);
  localparam logic [AW-1:0] LSB_OFF = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] target_q;
  logic [AW-1:0] mask_q;
  logic [4:0]    cyc_q;
  logic          post_q;
  logic [AW-1:0] diff;
  logic          enabled;

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      mask_q   <= '0;
      cyc_q    <= '0;
      post_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_TARGET: target_q <= wr_data;
        SEL_MASK:   mask_q   <= wr_data;
        SEL_CTRL: begin
          cyc_q  <= wr_data[4:0];
          post_q <= wr_data[CTRL_POST_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    enabled   = (cyc_q == CYC_IFETCH_WORD);
    diff      = (fet_addr ^ target_q) & ~mask_q & LSB_OFF;
    hit       = enabled && (diff == '0);
    post_mode = post_q;
  end
endmodule

// File: rtl/ifbrk_tag_fifo.sv
module ifbrk_tag_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (flush) begin
        rd_ptr <= wr_ptr;
        count  <= (PW+1)'(push);
      end else begin
        if (pop) rd_ptr <= rd_ptr + 1'b1;
        count <= count + (PW+1)'(push) - (PW+1)'(pop);
      end
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/ifbrk_deliver.sv
module ifbrk_deliver #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ex_valid,
  input  logic           ex_branch,
  input  logic           ex_inhibit,
  input  logic [NCH-1:0] head_tag,
  input  logic [NCH-1:0] post_mode,
  input  logic           brk_ack,
  input  logic [NCH-1:0] clr_mask,
  output logic           brk_irq,
  output logic [NCH-1:0] brk_flag
);
  logic           prev_block;
  logic [NCH-1:0] held;
  logic [NCH-1:0] held_nx;
  logic [NCH-1:0] pre_hit;
  logic [NCH-1:0] post_hit;
  logic [NCH-1:0] deliver;
  logic           ok_before;
  logic           ok_after;

  always_comb begin
    pre_hit   = head_tag & ~post_mode;
    post_hit  = head_tag & post_mode;
    ok_before = !prev_block;
    ok_after  = !(ex_branch || ex_inhibit);
    deliver   = '0;
    held_nx   = held;
    if (ex_valid) begin
      if (ok_after) begin
        deliver = held | pre_hit | post_hit;
        held_nx = '0;
      end else if (ok_before) begin
        deliver = held | pre_hit;
        held_nx = post_hit;
      end else begin
        held_nx = held | pre_hit | post_hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_block <= 1'b0;
      held       <= '0;
      brk_irq    <= 1'b0;
      brk_flag   <= '0;
    end else begin
      if (ex_valid) prev_block <= !ok_after;
      held     <= held_nx;
      brk_irq  <= (|deliver) || (brk_irq && !brk_ack);
      brk_flag <= (brk_flag & ~clr_mask) | deliver;
    end
  end
endmodule

// File: rtl/ifbrk_unit.sv
module ifbrk_unit
  import ifbrk_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int AW     = 32,
  parameter int QDEPTH = 4,
  localparam int CHW   = $clog2(NCH),
  localparam int CW    = CHW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           fet_valid,
  input  logic           fet_start,
  input  logic [AW-1:0]  fet_addr,
  input  logic           ex_valid,
  input  logic           ex_branch,
  input  logic           ex_inhibit,
  input  logic           ex_flush,
  input  logic           brk_ack,
  output logic           brk_irq,
  output logic [NCH-1:0] brk_flag
);
  localparam int QCW = $clog2(QDEPTH) + 1;

  logic [CHW-1:0] wr_ch;
  sel_e           wr_sel;
  logic [NCH-1:0] ch_hit;
  logic [NCH-1:0] ch_post;
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] head_tag;
  logic [QCW-1:0] q_count;
  logic           q_push;

  assign wr_ch  = cfg_addr[CW-1:2];
  assign wr_sel = sel_e'(cfg_addr[1:0]);
  assign q_push = fet_valid && fet_start;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ifbrk_chan #(.AW(AW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (cfg_we && (wr_ch == CHW'(g))),
      .wr_sel    (wr_sel),
      .wr_data   (cfg_wdata),
      .fet_addr  (fet_addr),
      .hit       (ch_hit[g]),
      .post_mode (ch_post[g])
    );
    assign clr_mask[g] = cfg_we && (wr_ch == CHW'(g)) &&
                         (wr_sel == SEL_STAT) && !cfg_wdata[0];
  end

  ifbrk_tag_fifo #(.W(NCH), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .din   (ch_hit),
    .pop   (ex_valid),
    .flush (ex_flush),
    .dout  (head_tag),
    .count (q_count)
  );

  ifbrk_deliver #(.NCH(NCH)) u_deliver (
    .clk        (clk),
    .rst        (rst),
    .ex_valid   (ex_valid),
    .ex_branch  (ex_branch),
    .ex_inhibit (ex_inhibit),
    .head_tag   (head_tag),
    .post_mode  (ch_post),
    .brk_ack    (brk_ack),
    .clr_mask   (clr_mask),
    .brk_irq    (brk_irq),
    .brk_flag   (brk_flag)
  );
endmodule

// File: rtl/ifbrk_chk.sv
module ifbrk_chk #(
  parameter int NCH    = 4,
  parameter int CW     = 4,
  parameter int AW     = 32,
  parameter int QDEPTH = 4,
  parameter int QCW    = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_we,
  input logic [CW-1:0]  cfg_addr,
  input logic [AW-1:0]  cfg_wdata,
  input logic           fet_valid,
  input logic           fet_start,
  input logic           ex_valid,
  input logic           ex_flush,
  input logic           brk_ack,
  input logic           brk_irq,
  input logic [NCH-1:0] brk_flag,
  input logic [QCW-1:0] q_count
);
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    brk_irq && !brk_ack |=> brk_irq); // R10

  AST_IRQ_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    !brk_irq && !ex_valid |=> !brk_irq); // R5

  AST_FLAG_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> (brk_flag & ~$past(brk_flag)) == '0); // R6

  AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    (|(brk_flag & ~$past(brk_flag))) |-> brk_irq); // R12

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|($past(brk_flag) & ~brk_flag)) |->
      $past(cfg_we && cfg_addr[1:0] == 2'b11 && !cfg_wdata[0])); // R11

  AST_EXEC_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ex_valid |-> q_count != '0); // R5

  AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fet_valid && fet_start && !ex_valid && !ex_flush |-> q_count < QCW'(QDEPTH)); // R6
endmodule

bind ifbrk_unit ifbrk_chk #(
  .NCH(NCH), .CW(CW), .AW(AW), .QDEPTH(QDEPTH), .QCW(QCW)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .fet_valid (fet_valid),
  .fet_start (fet_start),
  .ex_valid  (ex_valid),
  .ex_flush  (ex_flush),
  .brk_ack   (brk_ack),
  .brk_irq   (brk_irq),
  .brk_flag  (brk_flag),
  .q_count   (q_count)
);

// File: tb/test_ifbrk_unit.sv
module test_ifbrk_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CW  = 4;
  localparam int NROWS = 17;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we = 1'b0;
  logic [CW-1:0]  cfg_addr = '0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic           fet_valid = 1'b0;
  logic           fet_start = 1'b0;
  logic [AW-1:0]  fet_addr = '0;
  logic           ex_valid = 1'b0;
  logic           ex_branch = 1'b0;
  logic           ex_inhibit = 1'b0;
  logic           ex_flush = 1'b0;
  logic           brk_ack = 1'b0;
  logic           brk_irq;
  logic [NCH-1:0] brk_flag;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifbrk_unit #(.NCH(NCH), .AW(AW), .QDEPTH(4)) i_ifbrk_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fet_valid(fet_valid), .fet_start(fet_start),
    .fet_addr(fet_addr), .ex_valid(ex_valid), .ex_branch(ex_branch),
    .ex_inhibit(ex_inhibit), .ex_flush(ex_flush), .brk_ack(brk_ack),
    .brk_irq(brk_irq), .brk_flag(brk_flag)
  );

  // Row: {addr[15:0], branch, inhibit, expected flags[3:0]}
  // Channels: 0 @0x100 before, 1 @0x200 after, 2 @0x300 mask 0xFC before, 3 @0x100 after
  localparam logic [21:0] VEC [NROWS] = '{
    {16'h0100, 1'b0, 1'b0, 4'b1001},  // R12 R4 both modes on one instruction
    {16'h0104, 1'b0, 1'b0, 4'b0000},  // R3 no hit
    {16'h0200, 1'b0, 1'b0, 4'b0010},  // R7 after-break delivered
    {16'h0200, 1'b1, 1'b0, 4'b0000},  // R9 after-break on delayed branch held
    {16'h0206, 1'b0, 1'b0, 4'b0010},  // R9 released after delay slot
    {16'h0100, 1'b0, 1'b1, 4'b0001},  // R9 before goes, after held by inhibit
    {16'h0108, 1'b0, 1'b0, 4'b1000},  // R9 held channel 3 released
    {16'h0108, 1'b1, 1'b0, 4'b0000},  // branch, nothing
    {16'h0100, 1'b0, 1'b0, 4'b1001},  // R8 before-break in delay slot, released after it
    {16'h03A4, 1'b0, 1'b0, 4'b0100},  // R3 masked compare hits
    {16'h0402, 1'b0, 1'b0, 4'b0000},  // R3 outside mask
    {16'h0200, 1'b0, 1'b1, 4'b0000},  // R9 inhibit holds after-break
    {16'h0110, 1'b1, 1'b0, 4'b0000},  // R9 still blocked by branch
    {16'h0112, 1'b0, 1'b0, 4'b0010},  // R9 released
    {16'h010A, 1'b1, 1'b0, 4'b0000},  // branch
    {16'h0100, 1'b0, 1'b1, 4'b0000},  // R8 delay slot and inhibit: all held
    {16'h010C, 1'b0, 1'b0, 4'b1001}   // R8 released together
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [3:0] exp);
    check(req, 32'(brk_irq), 32'(|exp));
    check(req, 32'(brk_flag), 32'(exp));
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    cfg_we = 1'b1;
    cfg_addr = CW'((ch << 2) | sel);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic start);
    fet_valid = 1'b1;
    fet_start = start;
    fet_addr = a;
    @(negedge clk);
    fet_valid = 1'b0;
    fet_start = 1'b0;
  endtask

  task automatic exec(input logic b, input logic i, input logic f);
    ex_valid = 1'b1;
    ex_branch = b;
    ex_inhibit = i;
    ex_flush = f;
    @(negedge clk);
    ex_valid = 1'b0;
    ex_branch = 1'b0;
    ex_inhibit = 1'b0;
    ex_flush = 1'b0;
  endtask

  task automatic clear_all;
    brk_ack = 1'b1;
    wr(0, 3, 32'h0);
    brk_ack = 1'b0;
    for (int c = 1; c < NCH; c++) wr(c, 3, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_out("R1 reset state", 4'b0000);

    fetch(32'h100, 1'b1);
    exec(1'b0, 1'b0, 1'b0);
    check_out("R1 channels disabled after reset", 4'b0000);

    wr(0, 0, 32'h100); wr(0, 2, 32'h00F);
    wr(1, 0, 32'h200); wr(1, 2, 32'h10F);
    wr(2, 0, 32'h300); wr(2, 1, 32'h0FC); wr(2, 2, 32'h00F);
    wr(3, 0, 32'h100); wr(3, 2, 32'h10F);

    for (int r = 0; r < NROWS; r++) begin
      fetch({16'h0, VEC[r][21:6]}, 1'b1);
      exec(VEC[r][5], VEC[r][4], 1'b0);
      check_out($sformatf("table row %0d (R3 R4 R7 R8 R9 R12)", r), VEC[r][3:0]);
      clear_all();
    end

    // R5: a fetch match alone raises nothing until execution
    fetch(32'h100, 1'b1);
    repeat (3) @(negedge clk);
    check_out("R5 no break before execution", 4'b0000);
    exec(1'b0, 1'b0, 1'b0);
    check_out("R5 break on execution", 4'b1001);

    // R10: request held without acknowledge, dropped by it
    repeat (2) @(negedge clk);
    check("R10 request held until ack", 32'(brk_irq), 32'd1);
    brk_ack = 1'b1;
    @(negedge clk);
    brk_ack = 1'b0;
    check("R10 request dropped by ack", 32'(brk_irq), 32'd0);
    check("R11 flags kept over ack", 32'(brk_flag), 32'h9);

    // R11: write of one keeps, write of zero clears
    wr(0, 3, 32'h1);
    check("R11 write one keeps flag", 32'(brk_flag), 32'h9);
    wr(0, 3, 32'h0);
    check("R11 write zero clears channel 0", 32'(brk_flag), 32'h8);
    wr(3, 3, 32'h0);
    check("R11 write zero clears channel 3", 32'(brk_flag), 32'h0);

    // R6: overrun fetch discarded by a flush never breaks
    fetch(32'h104, 1'b1);
    fetch(32'h100, 1'b1);
    exec(1'b0, 1'b0, 1'b1);
    check_out("R6 flushed instruction ignored", 4'b0000);
    fetch(32'h108, 1'b1);
    exec(1'b0, 1'b0, 1'b0);
    check_out("R6 no stale tag after flush", 4'b0000);

    // R3: continuation halfword at target address never matches
    fetch(32'h0FE, 1'b1);
    fetch(32'h100, 1'b0);
    exec(1'b0, 1'b0, 1'b0);
    check_out("R3 continuation halfword ignored", 4'b0000);

    // R2: byte size setting on channel 0 disables it
    wr(0, 2, 32'h007);
    fetch(32'h100, 1'b1);
    exec(1'b0, 1'b0, 1'b0);
    check_out("R2 wrong bus cycle setting", 4'b1000);
    clear_all();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule